// File: doc/BRIEF.md
# QRSS Pattern Sync Detector

This block sits on the receive side of one transmission loop. It checks a serial test stream against the quasi-random signal source sequence. A local generator is loaded from the incoming bits while the detector is hunting. Once enough consecutive bits agree with its predictions, the generator runs on its own and every later bit is compared with what the sequence should carry. One instance is placed for each loop.

While in sync, each disagreeing bit advances a wrapping error counter. When errors come too densely, sync is dropped and the detector goes back to hunting. A wrap of the counter sets a sticky overflow flag and a maskable interrupt status bit. Management logic reads and clears these through single-cycle strobes.

Top module: `qrss_rx_mon`

## Requirements
- R1: After reset, `sync_lost` is 1, and `err_count`, `ovf_flag`, `irq_stat` and `irq` are all 0.
- R2: The expected sequence obeys b[n] = b[n-3] XOR b[n-20], which is the x^20 + x^17 + 1 recurrence. An expected bit is forced to 1 when the 14 preceding recurrence bits were all zero. While in sync, the generator runs on its own recurrence and ignores the received values.
- R3: `sync_lost` falls after a run of 32 consecutive enabled bits that match the prediction. It stays 1 until at least 32 enabled bits have been received since reset or since the last loss.
- R4: While in sync, each enabled bit that differs from the prediction raises `err_count` by exactly one, and the new value shows on the clock edge that takes that bit.
- R5: While `sync_lost` is 1, mismatching bits leave `err_count` unchanged.
- R6: While in sync, if the latest 64 enabled bits hold 6 or more mismatches, `sync_lost` rises on the edge that takes the sixth of them. At most 5 mismatches in every such window keep sync.
- R7: A clock cycle with `bit_en` low changes neither the generator position, the sync state nor the error counter, whatever `bit_in` carries.
- R8: `err_count` is CNT_W bits wide and wraps from all ones to zero. That wrap sets `ovf_flag`, which stays 1 until a cycle with `ovf_clr` high.
- R9: The same wrap sets `irq_stat`, which is cleared only by `irq_clr`. `irq` is `irq_stat` AND `irq_en`, and the enable never blocks the status bit from being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Qualifies `bit_in` in this cycle |
| bit_in | input | 1 | Received serial data bit |
| ovf_clr | input | 1 | Clear strobe for `ovf_flag` |
| irq_en | input | 1 | Interrupt enable for the overflow status |
| irq_clr | input | 1 | Clear strobe for `irq_stat` |
| sync_lost | output | 1 | 1 while the pattern is not in sync |
| err_count | output | CNT_W | Bit error counter |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| irq_stat | output | 1 | Sticky interrupt status |
| irq | output | 1 | Masked interrupt request |

## Verification
The first corner case is the lock threshold. A detector that locked on 31 bits, or that counted bits with `bit_en` low, would show sync too early. A generator with a wrong tap would never lock at all.

Loss detection is driven with a window of exactly 5 errors and then with one of 6 that spans two error phases. An off-by-one window length or threshold would drop sync during the first or hold it through the second. Errors sent while hunting would show up as extra counts in a design that counts in every state.

The counter is pushed through its wrap with the interrupt both enabled and masked. A non-sticky flag, a status bit gated by the enable, or a clear strobe that touches the wrong bit each leave a visible difference.

// File: rtl/qrss_pkg.sv
package qrss_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } sync_state_e;

endpackage

// File: rtl/qrss_pattern_gen.sv
module qrss_pattern_gen #(
  parameter int unsigned POLY_LEN = 20,
  parameter int unsigned TAP      = 3,
  parameter int unsigned ZERO_RUN = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic locked,
  input  logic rx_bit,
  output logic exp_bit,
  output logic mismatch
);

  logic [POLY_LEN-1:0] hist_q;
  logic [POLY_LEN-1:0] hist_d;
  logic                raw_pred;
  logic                forced;
  logic                feed;

  // recurrence bit predicted from history (hist_q[0] is the newest bit)
  always_comb begin
    raw_pred = hist_q[TAP-1] ^ hist_q[POLY_LEN-1];
    forced   = (hist_q[ZERO_RUN-1:0] == '0);
    exp_bit  = raw_pred | forced;
    mismatch = rx_bit ^ exp_bit;
    feed     = locked ? raw_pred : rx_bit;
    hist_d   = hist_q;
    if (adv) begin
      hist_d = {hist_q[POLY_LEN-2:0], feed};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

  // R7: generator position holds when no bit is presented
  a_r7_hist_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(hist_q));

  // R2: while locked the newest history bit follows the recurrence, not the line
  a_r2_free_run : assert property (@(posedge clk) disable iff (!rst_n)
    (adv && locked) |=> (hist_q[0] == ($past(hist_q[TAP-1]) ^ $past(hist_q[POLY_LEN-1]))));

endmodule

// File: rtl/qrss_sync_fsm.sv
module qrss_sync_fsm
  import qrss_pkg::*;
#(
  parameter int unsigned LOCK_CNT = 32,
  parameter int unsigned WIN_LEN  = 64,
  parameter int unsigned WIN_ERR  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic mismatch,
  output logic locked,
  output logic bit_err
);

  localparam int unsigned RUN_W  = $clog2(LOCK_CNT + 1);
  localparam int unsigned WCNT_W = $clog2(WIN_LEN + 1);

  sync_state_e         state_q, state_d;
  logic [RUN_W-1:0]    run_q, run_d;
  logic [WIN_LEN-2:0]  win_q, win_d;
  logic [WCNT_W-1:0]   wcnt_q, wcnt_d;
  logic [WCNT_W-1:0]   win_sum;

  assign locked  = (state_q == ST_LOCK);
  assign bit_err = adv && locked && mismatch;

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    win_d   = win_q;
    wcnt_d  = wcnt_q;
    win_sum = wcnt_q + WCNT_W'(bit_err);
    if (adv) begin
      case (state_q)
        ST_HUNT: begin
          if (mismatch) begin
            run_d = '0;
          end else if (run_q == RUN_W'(LOCK_CNT - 1)) begin
            state_d = ST_LOCK;
            run_d   = '0;
            win_d   = '0;
            wcnt_d  = '0;
          end else begin
            run_d = run_q + RUN_W'(1);
          end
        end
        ST_LOCK: begin
          if (win_sum >= WCNT_W'(WIN_ERR)) begin
            state_d = ST_HUNT;
            run_d   = '0;
            win_d   = '0;
            wcnt_d  = '0;
          end else begin
            win_d  = {win_q[WIN_LEN-3:0], mismatch};
            wcnt_d = win_sum - WCNT_W'(win_q[WIN_LEN-2]);
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      run_q   <= '0;
      win_q   <= '0;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      win_q   <= win_d;
      wcnt_q  <= wcnt_d;
    end
  end

  // R3: entering lock only at the end of a full matching run
  a_r3_lock_after_run : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(run_q) == RUN_W'(LOCK_CNT - 1)));

  // R6: in lock the window count stays below the loss threshold
  a_r6_window_bound : assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (wcnt_q < WCNT_W'(WIN_ERR)));

  // R6: leaving lock only on an errored bit
  a_r6_loss_on_error : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(bit_err));

  // R7: no state movement without a bit
  a_r7_state_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(state_q) && $stable(run_q) && $stable(wcnt_q)));

endmodule

// File: rtl/qrss_err_stats.sv
module qrss_err_stats #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_err,
  input  logic             ovf_clr,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] err_count,
  output logic             ovf_flag,
  output logic             irq_stat,
  output logic             irq
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             ist_q, ist_d;
  logic             wrap;

  always_comb begin
    wrap  = bit_err && (cnt_q == '1);
    cnt_d = cnt_q;
    if (bit_err) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    ovf_d = wrap | (ovf_q & ~ovf_clr);
    ist_d = wrap | (ist_q & ~irq_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      ist_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      ist_q <= ist_d;
    end
  end

  assign err_count = cnt_q;
  assign ovf_flag  = ovf_q;
  assign irq_stat  = ist_q;
  assign irq       = ist_q & irq_en;

  // R5: counter holds when no counted error arrives
  a_r5_cnt_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !bit_err |=> $stable(cnt_q));

  // R4: one step per counted error
  a_r4_cnt_step : assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  // R8: overflow flag is sticky until cleared
  a_r8_ovf_sticky : assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

  // R8: overflow flag rises only together with a wrap to zero
  a_r8_ovf_on_wrap : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> (cnt_q == '0 && $past(cnt_q) == '1));

  // R9: status is set by the same wrap regardless of enable
  a_r9_stat_with_ovf : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> ist_q);

endmodule

// File: rtl/qrss_rx_mon.sv
module qrss_rx_mon #(
  parameter int unsigned POLY_LEN = 20,
  parameter int unsigned TAP      = 3,
  parameter int unsigned ZERO_RUN = 14,
  parameter int unsigned LOCK_CNT = 32,
  parameter int unsigned WIN_LEN  = 64,
  parameter int unsigned WIN_ERR  = 6,
  parameter int unsigned CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             ovf_clr,
  input  logic             irq_en,
  input  logic             irq_clr,
  output logic             sync_lost,
  output logic [CNT_W-1:0] err_count,
  output logic             ovf_flag,
  output logic             irq_stat,
  output logic             irq
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       locked;
  logic       exp_bit;
  logic       mismatch;
  logic       bit_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  qrss_pattern_gen #(
    .POLY_LEN (POLY_LEN),
    .TAP      (TAP),
    .ZERO_RUN (ZERO_RUN)
  ) u_gen (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .adv      (bit_en),
    .locked   (locked),
    .rx_bit   (bit_in),
    .exp_bit  (exp_bit),
    .mismatch (mismatch)
  );

  qrss_sync_fsm #(
    .LOCK_CNT (LOCK_CNT),
    .WIN_LEN  (WIN_LEN),
    .WIN_ERR  (WIN_ERR)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .adv      (bit_en),
    .mismatch (mismatch),
    .locked   (locked),
    .bit_err  (bit_err)
  );

  qrss_err_stats #(
    .CNT_W (CNT_W)
  ) u_stats (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bit_err   (bit_err),
    .ovf_clr   (ovf_clr),
    .irq_en    (irq_en),
    .irq_clr   (irq_clr),
    .err_count (err_count),
    .ovf_flag  (ovf_flag),
    .irq_stat  (irq_stat),
    .irq       (irq)
  );

  assign sync_lost = ~locked;

  // R1: internal reset holds the detector out of sync
  a_r1_reset_hunt : assert property (@(posedge clk)
    !rst_int_n |=> (sync_lost || !rst_int_n));

  // R5: an unlocked cycle never moves the counter
  a_r5_unlocked_hold : assert property (@(posedge clk) disable iff (!rst_int_n)
    sync_lost |=> $stable(err_count));

endmodule

// File: tb/sim_qrss_rx_mon.sv
module sim_qrss_rx_mon;

  localparam int unsigned CW = 8;

  logic          clk;
  logic          rst_n;
  logic          bit_en;
  logic          bit_in;
  logic          ovf_clr;
  logic          irq_en;
  logic          irq_clr;
  logic          sync_lost;
  logic [CW-1:0] err_count;
  logic          ovf_flag;
  logic          irq_stat;
  logic          irq;

  int n_chk;
  int n_fail;
  logic [19:0] h;

  qrss_rx_mon #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .ovf_clr(ovf_clr), .irq_en(irq_en), .irq_clr(irq_clr),
    .sync_lost(sync_lost), .err_count(err_count), .ovf_flag(ovf_flag),
    .irq_stat(irq_stat), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [15:0] nbits;
    logic [7:0]  period;
    logic        lost;
    logic [7:0]  cnt;
    logic        ovf;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{nbits: 16'd100,  period: 8'd0,  lost: 1'b0, cnt: 8'd0,   ovf: 1'b0},
    '{nbits: 16'd128,  period: 8'd16, lost: 1'b0, cnt: 8'd8,   ovf: 1'b0},
    '{nbits: 16'd64,   period: 8'd13, lost: 1'b0, cnt: 8'd12,  ovf: 1'b0},
    '{nbits: 16'd60,   period: 8'd10, lost: 1'b1, cnt: 8'd17,  ovf: 1'b0},
    '{nbits: 16'd60,   period: 8'd0,  lost: 1'b0, cnt: 8'd17,  ovf: 1'b0},
    '{nbits: 16'd3808, period: 8'd16, lost: 1'b0, cnt: 8'd255, ovf: 1'b0},
    '{nbits: 16'd16,   period: 8'd16, lost: 1'b0, cnt: 8'd0,   ovf: 1'b1}
  };

  function automatic string vec_req(int idx);
    case (idx)
      0: return "R2 clean run in sync";
      1: return "R4 sparse errors counted";
      2: return "R6 five errors per window hold sync";
      3: return "R6 sixth error drops sync, R5 later error ignored";
      4: return "R3 relock, R5 hunting mismatches not counted";
      5: return "R4 long error run";
      default: return "R8 counter wrap sets overflow";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic err);
    logic raw;
    logic tb;
    raw = h[2] ^ h[19];
    tb  = raw | (h[13:0] == 14'd0);
    h   = {h[18:0], raw};
    @(negedge clk);
    bit_en = 1'b1;
    bit_in = tb ^ err;
  endtask

  task automatic run_phase(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      send(period != 0 && (i % period) == period - 1);
    end
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    h = 20'hA5C3E;
    rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b0;
    ovf_clr = 1'b0; irq_en = 1'b1; irq_clr = 1'b0;
    do_reset();

    // R1 reset state
    chk("R1 sync_lost", 32'(sync_lost), 32'd1);
    chk("R1 err_count", 32'(err_count), 32'd0);
    chk("R1 ovf_flag", 32'(ovf_flag), 32'd0);
    chk("R1 irq_stat", 32'(irq_stat), 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);

    // R3 lock threshold
    run_phase(31, 0);
    chk("R3 no lock before 32 bits", 32'(sync_lost), 32'd1);
    run_phase(21, 0);
    chk("R3 lock within 52 clean bits", 32'(sync_lost), 32'd0);
    chk("R5 no counts while hunting", 32'(err_count), 32'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      run_phase(int'(VEC[v].nbits), int'(VEC[v].period));
      chk({vec_req(v), " sync_lost"}, 32'(sync_lost), 32'(VEC[v].lost));
      chk({vec_req(v), " err_count"}, 32'(err_count), 32'(VEC[v].cnt));
      chk({vec_req(v), " ovf_flag"}, 32'(ovf_flag), 32'(VEC[v].ovf));
    end
    chk("R9 irq_stat after wrap", 32'(irq_stat), 32'd1);
    chk("R9 irq enabled", 32'(irq), 32'd1);

    // R8 overflow clear leaves interrupt status alone
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk("R8 ovf cleared", 32'(ovf_flag), 32'd0);
    chk("R9 stat kept on ovf clear", 32'(irq_stat), 32'd1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk("R9 stat cleared", 32'(irq_stat), 32'd0);
    chk("R9 irq dropped", 32'(irq), 32'd0);

    // R7 disabled cycles with noisy data
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      bit_en = 1'b0;
      bit_in = k[0] ^ k[2];
    end
    @(negedge clk);
    chk("R7 sync held with bit_en low", 32'(sync_lost), 32'd0);
    chk("R7 count held with bit_en low", 32'(err_count), 32'd0);
    run_phase(64, 0);
    chk("R7 generator did not advance", 32'(err_count), 32'd0);
    chk("R7 still in sync", 32'(sync_lost), 32'd0);

    // R9 masked interrupt
    irq_en = 1'b0;
    run_phase(4096, 16);
    chk("R8 second wrap count", 32'(err_count), 32'd0);
    chk("R8 second wrap flag", 32'(ovf_flag), 32'd1);
    chk("R9 stat set while masked", 32'(irq_stat), 32'd1);
    chk("R9 irq masked", 32'(irq), 32'd0);
    irq_en = 1'b1;
    #1;
    chk("R9 irq on enable", 32'(irq), 32'd1);

    // R1 reset mid-run
    do_reset();
    chk("R1 sync_lost after reset", 32'(sync_lost), 32'd1);
    chk("R1 count after reset", 32'(err_count), 32'd0);
    chk("R1 ovf after reset", 32'(ovf_flag), 32'd0);
    chk("R1 stat after reset", 32'(irq_stat), 32'd0);
    chk("R1 irq after reset", 32'(irq), 32'd0);

    summary();
  end

endmodule